// File: doc/BRIEF.md
# Fractional-N Feedback Divider Core

This block is the digital heart of the feedback path of a fractional-N frequency synthesizer. Its clock is the oscillator output after a fixed divide-by-two stage. It models a dual-modulus 4/5 prescaler that feeds a programmable counter of modulus 14, 15 or 16. It emits one single-clock feedback pulse per division cycle, which goes to the phase detector. The ratio in the oscillator domain is therefore always twice the ratio this block applies.

A three-stage cascade of 10-bit first-order accumulators chooses the ratio of each division cycle. Its combined output is a signed offset from -3 to +4. This offset is added to a base of 59 plus a 2-bit channel number, giving a per-cycle ratio between 56 and 66. Over many cycles the ratio averages to 59 + channel + fraction/1024.

In frequency-shift mode a data bit moves the fraction up or down by a programmable deviation, and the result is clamped to the 10-bit range. In on-off mode the fraction, and with it the frequency, stays fixed. All configuration arrives as static inputs.

Top module: `fnd_frac_divider`

## Requirements
- R1: A synchronous active-low reset clears every accumulator and delay stage. After reset, `fb_pulse` is 0 and `mod_ctrl` is 0. Following reset, the first division cycles are exactly 59 + channel clocks long while the effective fraction is 0.
- R2: `fb_pulse` is high for exactly one clock per division cycle. When the block is enabled and idle, the first pulse appears one clock after the enable is sampled high.
- R3: Every division cycle lasts 4·P + S input clocks, where P = 14 + `mod_ctrl[3:2]` and S = `mod_ctrl[1:0]`. `mod_ctrl` takes the cycle's setting at the clock edge that raises the cycle's starting pulse and holds it until the next pulse. Configuration changes never alter a cycle that is already in progress.
- R4: Each cycle length lies within [59 + channel − 3, 59 + channel + 4], and therefore within 56..66. P lies in 14..16 and S in 0..3.
- R5: For a constant effective fraction Fe, the total length of any M consecutive cycles differs from M·(59 + channel) + M·Fe/1024 by less than 4 clocks.
- R6: With an effective fraction of 0 from reset onward, every cycle is exactly 59 + channel clocks.
- R7: With `fsk_en`=1, the effective fraction is `frac` + `fsk_dev` when `fsk_bit`=1 and `frac` − `fsk_dev` when `fsk_bit`=0.
- R8: The effective fraction saturates at 1023 on overflow and at 0 on underflow. It never wraps.
- R9: With `fsk_en`=0, the effective fraction is `frac`, and neither `fsk_bit` nor `fsk_dev` has any effect.
- R10: While `synth_en` is low, `fb_pulse` is 0 from the clock after enable is sampled low. When enable returns, a new cycle starts with a pulse one clock after enable is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock after the fixed divide-by-two |
| rst_n | input | 1 | Synchronous active-low reset |
| synth_en | input | 1 | Divider enable; low holds the output low |
| chan | input | 2 | Integer channel added to the base ratio 59 |
| frac | input | 10 | Fractional part of the ratio, in units of 1/1024 |
| fsk_en | input | 1 | 1 selects frequency-shift mode, 0 on-off mode |
| fsk_bit | input | 1 | Transmit data bit used in frequency-shift mode |
| fsk_dev | input | 10 | Fraction deviation applied by the data bit |
| fb_pulse | output | 1 | One-clock feedback pulse at the start of each cycle |
| mod_ctrl | output | 4 | Modulus control of the current cycle: [3:2] counter select, [1:0] swallow count |

## Verification
The assertions check on every clock that the pulse is one clock wide and that it stays low while the block is disabled. They also check that the modulus setting holds for a whole cycle, that each cycle's clock count equals 4·P + S, and that every loaded P and S lies within range. Several behaviours appear only over the bench's scenarios: the long-run average ratio and its exact value with a zero fraction, the per-channel bounds, the frequency-shift offsets with saturation at both ends, and the data bit having no effect in on-off mode.

// File: rtl/fnd_pkg.sv
// Package: shared constants for the fractional-N divider core.
// Assumes a base ratio of 59, a prescaler of 4/5 and a counter of 14..16.
package fnd_pkg;
    localparam int FRAC_W   = 10;  // accumulator / fraction width
    localparam int CH_W     = 2;   // channel field width
    localparam int BASE_N   = 59;  // ratio with channel 0 and zero offset
    localparam int NSTAGE   = 3;   // cascaded accumulator stages
    localparam int OFF_W    = 4;   // signed offset width (-3..+4)
    localparam int P_MIN    = 14;  // smallest programmable counter modulus
    localparam int P_W      = 5;   // counter modulus register width
    localparam int PSEL_W   = 2;   // encoded counter selection width
    localparam int S_W      = 2;   // swallow count width
    localparam int PRE_W    = 3;   // prescaler phase counter width
    localparam int PRE_HI   = 4;   // last prescaler phase when dividing by 5
    localparam int LEN_W    = 7;   // width able to hold a full cycle length
endpackage

// File: rtl/fnd_frac_sel.sv
// Module: chooses the effective fraction for the modulator.
// In frequency-shift mode the data bit adds or subtracts the deviation and
// the result is clamped to the fraction range; otherwise the fraction passes.
// Purely combinational; the inputs are assumed static between data changes.
module fnd_frac_sel #(
    parameter int FRAC_W = fnd_pkg::FRAC_W
) (
    input  logic [FRAC_W-1:0] frac,
    input  logic [FRAC_W-1:0] dev,
    input  logic              fsk_en,
    input  logic              fsk_bit,
    output logic [FRAC_W-1:0] frac_eff
);
    logic [FRAC_W:0] up_sum;
    logic [FRAC_W:0] dn_sum;

    // Widened sum and difference so that overflow and borrow are visible.
    always_comb begin
        up_sum = {1'b0, frac} + {1'b0, dev};
        dn_sum = {1'b0, frac} - {1'b0, dev};
    end

    // Pick the fraction and clamp at either end of the range.
    always_comb begin
        if (!fsk_en) begin
            frac_eff = frac;
        end else if (fsk_bit) begin
            frac_eff = up_sum[FRAC_W] ? {FRAC_W{1'b1}} : up_sum[FRAC_W-1:0];
        end else begin
            frac_eff = dn_sum[FRAC_W] ? {FRAC_W{1'b0}} : dn_sum[FRAC_W-1:0];
        end
    end
endmodule

// File: rtl/fnd_mash3.sv
// Module: three cascaded first-order accumulators with noise-cancelling
// recombination. The offset presented now belongs to the next division
// cycle; `step` commits it and advances all stages together.
// Assumes `step` pulses exactly once per division cycle.
module fnd_mash3 #(
    parameter int FRAC_W = fnd_pkg::FRAC_W,
    parameter int OFF_W  = fnd_pkg::OFF_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step,
    input  logic [FRAC_W-1:0]       frac_in,
    output logic signed [OFF_W-1:0] offset
);
    localparam int NSTG = 3;

    logic [NSTG-1:0] cy;       // carry of each stage for this step
    logic            cy2_d;    // stage-2 carry of the previous step
    logic            cy3_d;    // stage-3 carry of the previous step
    logic            cy3_dd;   // stage-3 carry two steps back

    genvar g;
    generate
        for (g = 0; g < NSTG; g++) begin : g_stage
            logic [FRAC_W-1:0] acc_q;
            logic [FRAC_W-1:0] addend;
            logic [FRAC_W-1:0] sum;
            logic              carry;
            if (g == 0) begin : g_first
                assign addend = frac_in;
            end else begin : g_next
                assign addend = g_stage[g-1].sum;
            end
            assign {carry, sum} = {1'b0, acc_q} + {1'b0, addend};
            assign cy[g] = carry;
            // Residue register of this stage, advanced once per cycle.
            always_ff @(posedge clk) begin
                if (!rst_n)    acc_q <= '0;
                else if (step) acc_q <= sum;
            end
        end
    endgenerate

    // Delay line for the differentiated carries of stages two and three.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cy2_d  <= 1'b0;
            cy3_d  <= 1'b0;
            cy3_dd <= 1'b0;
        end else if (step) begin
            cy2_d  <= cy[1];
            cy3_d  <= cy[2];
            cy3_dd <= cy3_d;
        end
    end

    // Recombine: c1 + (1-z^-1)c2 + (1-z^-1)^2 c3.
    always_comb begin
        offset = $signed({{(OFF_W-1){1'b0}}, cy[0]})
               + $signed({{(OFF_W-1){1'b0}}, cy[1]})
               - $signed({{(OFF_W-1){1'b0}}, cy2_d})
               + $signed({{(OFF_W-1){1'b0}}, cy[2]})
               - $signed({{(OFF_W-2){1'b0}}, cy3_d, 1'b0})
               + $signed({{(OFF_W-1){1'b0}}, cy3_dd});
    end
endmodule

// File: rtl/fnd_ratio_map.sv
// Module: turns base + channel + offset into a counter modulus P and a
// swallow count S with ratio = 4*P + S. With ratios of 56..66 this is the
// ratio divided by four and its remainder. Combinational.
module fnd_ratio_map #(
    parameter int CH_W   = fnd_pkg::CH_W,
    parameter int OFF_W  = fnd_pkg::OFF_W,
    parameter int BASE_N = fnd_pkg::BASE_N,
    parameter int P_W    = fnd_pkg::P_W,
    parameter int S_W    = fnd_pkg::S_W
) (
    input  logic [CH_W-1:0]         chan,
    input  logic signed [OFF_W-1:0] offset,
    output logic [P_W-1:0]          next_p,
    output logic [S_W-1:0]          next_s
);
    int ratio;

    // Split the per-cycle ratio into prescaler periods and swallows.
    always_comb begin
        ratio  = BASE_N + int'(chan) + int'(offset);
        next_p = P_W'(ratio >>> S_W);
        next_s = S_W'(ratio);
    end
endmodule

// File: rtl/fnd_div_core.sv
// Module: cycle-accurate model of the 4/5 prescaler and the 14..16 counter.
// S prescaler periods of 5 clocks are followed by P-S periods of 4 clocks.
// The next P and S are latched when a cycle starts, and the pulse marks
// that start. Assumes S <= P, which holds for every ratio in 56..66.
module fnd_div_core #(
    parameter int P_W    = fnd_pkg::P_W,
    parameter int S_W    = fnd_pkg::S_W,
    parameter int PSEL_W = fnd_pkg::PSEL_W,
    parameter int PRE_W  = fnd_pkg::PRE_W,
    parameter int PRE_HI = fnd_pkg::PRE_HI,
    parameter int P_MIN  = fnd_pkg::P_MIN,
    parameter int LEN_W  = fnd_pkg::LEN_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [P_W-1:0]          next_p,
    input  logic [S_W-1:0]          next_s,
    output logic                    load,
    output logic                    fb_pulse,
    output logic [PSEL_W+S_W-1:0]   mod_ctrl
);
    logic             run;
    logic [PRE_W-1:0] pre_cnt;
    logic [S_W-1:0]   swl_left;
    logic [P_W-1:0]   prog_cnt;
    logic [P_W-1:0]   cur_p;
    logic [S_W-1:0]   cur_s;
    logic             mod5;
    logic             pre_last;
    logic             prog_last;
    logic             cycle_end;

    // Prescaler terminal phase and counter terminal count.
    always_comb begin
        mod5      = (swl_left != '0);
        pre_last  = (pre_cnt == (mod5 ? PRE_W'(PRE_HI) : PRE_W'(PRE_HI - 1)));
        prog_last = (prog_cnt == (cur_p - P_W'(1)));
        cycle_end = run && pre_last && prog_last;
        load      = en && (!run || cycle_end);
    end

    // Prescaler phase, swallow and counter state, plus the start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run      <= 1'b0;
            pre_cnt  <= '0;
            swl_left <= '0;
            prog_cnt <= '0;
            cur_p    <= P_W'(P_MIN);
            cur_s    <= '0;
            fb_pulse <= 1'b0;
        end else if (!en) begin
            run      <= 1'b0;
            pre_cnt  <= '0;
            swl_left <= '0;
            prog_cnt <= '0;
            fb_pulse <= 1'b0;
        end else begin
            fb_pulse <= load;
            if (load) begin
                run      <= 1'b1;
                pre_cnt  <= '0;
                prog_cnt <= '0;
                cur_p    <= next_p;
                cur_s    <= next_s;
                swl_left <= next_s;
            end else if (pre_last) begin
                pre_cnt  <= '0;
                prog_cnt <= prog_cnt + P_W'(1);
                if (mod5) swl_left <= swl_left - S_W'(1);
            end else begin
                pre_cnt  <= pre_cnt + PRE_W'(1);
            end
        end
    end

    assign mod_ctrl = {PSEL_W'(cur_p - P_W'(P_MIN)), cur_s};

    // Checker: clocks elapsed since the last cycle start.
    logic [LEN_W-1:0] len_cnt;
    logic [LEN_W-1:0] exp_len;
    always_ff @(posedge clk) begin
        if (!rst_n || load) len_cnt <= '0;
        else                len_cnt <= len_cnt + LEN_W'(1);
    end
    assign exp_len = LEN_W'({cur_p, 2'b00}) + LEN_W'(cur_s);

    assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |=> !fb_pulse);
    assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !fb_pulse);
    assert_mod_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && en && !load) |=> $stable(mod_ctrl));
    assert_cycle_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && run) |-> (len_cnt + LEN_W'(1) == exp_len));
    assert_mod_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cur_p >= P_W'(P_MIN) && cur_p <= P_W'(P_MIN + 2) && cur_s <= cur_p));
endmodule

// File: rtl/fnd_frac_divider.sv
// Module: top of the fractional-N feedback divider core. It connects the
// fraction selector, the three-stage modulator, the ratio mapper and the
// prescaler/counter model. The modulator steps on every cycle start.
module fnd_frac_divider #(
    parameter int FRAC_W = fnd_pkg::FRAC_W,
    parameter int CH_W   = fnd_pkg::CH_W,
    parameter int OFF_W  = fnd_pkg::OFF_W,
    parameter int P_W    = fnd_pkg::P_W,
    parameter int S_W    = fnd_pkg::S_W,
    parameter int PSEL_W = fnd_pkg::PSEL_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  synth_en,
    input  logic [CH_W-1:0]       chan,
    input  logic [FRAC_W-1:0]     frac,
    input  logic                  fsk_en,
    input  logic                  fsk_bit,
    input  logic [FRAC_W-1:0]     fsk_dev,
    output logic                  fb_pulse,
    output logic [PSEL_W+S_W-1:0] mod_ctrl
);
    logic [FRAC_W-1:0]       frac_eff;
    logic signed [OFF_W-1:0] offset;
    logic [P_W-1:0]          next_p;
    logic [S_W-1:0]          next_s;
    logic                    cyc_load;

    fnd_frac_sel #(.FRAC_W(FRAC_W)) u_sel (
        .frac(frac), .dev(fsk_dev), .fsk_en(fsk_en), .fsk_bit(fsk_bit),
        .frac_eff(frac_eff)
    );

    fnd_mash3 #(.FRAC_W(FRAC_W), .OFF_W(OFF_W)) u_mash (
        .clk(clk), .rst_n(rst_n), .step(cyc_load), .frac_in(frac_eff),
        .offset(offset)
    );

    fnd_ratio_map #(.CH_W(CH_W), .OFF_W(OFF_W), .P_W(P_W), .S_W(S_W)) u_map (
        .chan(chan), .offset(offset), .next_p(next_p), .next_s(next_s)
    );

    fnd_div_core #(.P_W(P_W), .S_W(S_W), .PSEL_W(PSEL_W)) u_core (
        .clk(clk), .rst_n(rst_n), .en(synth_en), .next_p(next_p),
        .next_s(next_s), .load(cyc_load), .fb_pulse(fb_pulse),
        .mod_ctrl(mod_ctrl)
    );
endmodule

// File: tb/tb_fnd_frac_divider.sv
module tb_fnd_frac_divider;
    logic       clk = 1'b0;
    logic       rst_n, synth_en, fsk_en, fsk_bit;
    logic [1:0] chan;
    logic [9:0] frac, fsk_dev;
    logic       fb_pulse;
    logic [3:0] mod_ctrl;

    int  n_chk = 0;
    int  n_bad = 0;
    int  cyc   = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    fnd_frac_divider dut (
        .clk(clk), .rst_n(rst_n), .synth_en(synth_en), .chan(chan),
        .frac(frac), .fsk_en(fsk_en), .fsk_bit(fsk_bit), .fsk_dev(fsk_dev),
        .fb_pulse(fb_pulse), .mod_ctrl(mod_ctrl)
    );

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            report();
        end
    end

    // Expected effective fraction, from R7, R8 and R9.
    function automatic int eff_frac(input int f, input int d, input bit en, input bit b);
        int v;
        if (!en) return f;
        v = b ? f + d : f - d;
        if (v > 1023) v = 1023;
        if (v < 0) v = 0;
        return v;
    endfunction

    // Count clocks up to and including the next pulse sample.
    task automatic wait_pulse(output int len);
        len = 0;
        do begin
            @(negedge clk);
            len++;
        end while (!fb_pulse);
    endtask

    // Measure n cycles: total length, mismatches with mod_ctrl, range errors.
    task automatic run_window(input int n, input int lo, input int hi,
                              output longint total, output int bad_mc, output int bad_rng);
        int len;
        int exp_len;
        wait_pulse(len);
        total = 0; bad_mc = 0; bad_rng = 0;
        for (int j = 0; j < n; j++) begin
            exp_len = 4 * (14 + int'(mod_ctrl[3:2])) + int'(mod_ctrl[1:0]);
            if (mod_ctrl[3:2] > 2'd2) bad_rng++;
            wait_pulse(len);
            total += len;
            if (len != exp_len) bad_mc++;
            if (len < lo || len > hi || len < 56 || len > 66) bad_rng++;
        end
    endtask

    // Apply a configuration, settle, then check R3, R4 and the R5 mean.
    task automatic mean_case(input int ch, input int f, input int d, input bit fe,
                             input bit b, input int n, input string tag);
        longint total, diff, ideal;
        int bm, br, fe_v;
        chan = 2'(ch); frac = 10'(f); fsk_dev = 10'(d); fsk_en = fe; fsk_bit = b;
        run_window(4, 0, 99, total, bm, br);
        fe_v  = eff_frac(f, d, fe, b);
        run_window(n, 59 + ch - 3, 59 + ch + 4, total, bm, br);
        check(bm == 0, {tag, " R3 len vs mod_ctrl"}, bm, 0);
        check(br == 0, {tag, " R4 cycle range"}, br, 0);
        ideal = 1024 * longint'(n) * (59 + ch) + longint'(n) * fe_v;
        diff  = 1024 * total - ideal;
        check(diff > -4096 && diff < 4096, {tag, " R5 mean ratio x1024"},
              1024 * total, ideal);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        longint total;
        int bm, br, len, highs;
        int ch_r, f_r;
        void'($urandom(32'd2024));
        rst_n = 1'b0; synth_en = 1'b1; chan = 2'd0; frac = 10'd0;
        fsk_en = 1'b0; fsk_bit = 1'b0; fsk_dev = 10'd0;
        repeat (3) @(negedge clk);
        check(fb_pulse == 1'b0, "R1 pulse in reset", fb_pulse, 0);
        check(mod_ctrl == 4'd0, "R1 mod_ctrl in reset", mod_ctrl, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(fb_pulse == 1'b1, "R2 first pulse after release", fb_pulse, 1);

        // R6 / R1: zero fraction from reset gives exactly 59 every cycle.
        run_window(40, 59, 59, total, bm, br);
        check(br == 0, "R6 exact ratio 59", br, 0);
        check(total == 40 * 59, "R1 cleared modulator total", total, 40 * 59);
        check(bm == 0, "R3 len vs mod_ctrl ch0", bm, 0);

        // Directed mean case, then constrained random configurations.
        mean_case(3, 512, 0, 1'b0, 1'b0, 512, "dir ch3 f512");
        for (int k = 0; k < 3; k++) begin
            ch_r = int'($urandom % 4);
            f_r  = int'($urandom % 1024);
            mean_case(ch_r, f_r, 0, 1'b0, 1'b0, 256, "random");
        end

        // R9: on-off mode ignores the data bit and the deviation.
        do_reset();
        chan = 2'd1; frac = 10'd0; fsk_en = 1'b0; fsk_bit = 1'b1; fsk_dev = 10'd300;
        run_window(20, 60, 60, total, bm, br);
        check(br == 0 && total == 20 * 60, "R9 bit ignored in on-off mode", total, 20 * 60);

        // R8 low end: 20 - 100 clamps to 0, so the ratio stays exactly 60.
        fsk_en = 1'b1; fsk_bit = 1'b0; frac = 10'd20; fsk_dev = 10'd100;
        run_window(20, 60, 60, total, bm, br);
        check(br == 0 && total == 20 * 60, "R8 clamp at zero", total, 20 * 60);

        // R7: data bit moves the fraction by the deviation both ways.
        mean_case(1, 300, 200, 1'b1, 1'b1, 256, "R7 fsk bit1");
        mean_case(1, 300, 200, 1'b1, 1'b0, 256, "R7 fsk bit0");
        // R8 high end: 1000 + 100 clamps to 1023.
        mean_case(2, 1000, 100, 1'b1, 1'b1, 256, "R8 clamp at 1023");

        // R10: disable silences the output; re-enable starts a new cycle.
        wait_pulse(len);
        @(negedge clk);
        synth_en = 1'b0;
        highs = 0;
        for (int j = 0; j < 80; j++) begin
            @(negedge clk);
            if (fb_pulse) highs++;
        end
        check(highs == 0, "R10 no pulse while disabled", highs, 0);
        synth_en = 1'b1;
        @(negedge clk);
        check(fb_pulse == 1'b1, "R10 pulse after re-enable", fb_pulse, 1);
        @(negedge clk);
        check(fb_pulse == 1'b0, "R2 pulse one clock wide", fb_pulse, 0);
        report();
    end
endmodule